// File: doc/BRIEF.md
# Host Interface Configuration and Status Registers

This block holds the two registers a host uses to configure and monitor a device's host interface. The 32-bit configuration word carries a fixed device identifier, the control bits that steer the interface (interrupt enables, embedded CPU reset and clock gating, access mode and byte-ordering mode), and six sticky error flags. Each flag records one kind of buffer misuse by the host. The 16-bit control word reports the type of the next outgoing frame, the ready status and the length of the next output item. It also holds a host-written wake-up request.

Logic around the block reports misuse events as one-cycle pulses and supplies the live status inputs. The host reads and writes through a simple request port. Read data is registered. Reading the configuration word returns the error flags and clears them in the same access. An interrupt request is formed from the pending-data and ready inputs, each gated by its enable bit.

Top module: `hif_status_regs`

## Requirements
- R1: Configuration bits 31:24 always read 0x01, and bits 23:20 and bit 0 always read 0. Writes cannot change these bits.
- R2: After reset the configuration word reads 0x01005400. This means CPU reset (bit 14), CPU clock disable (bit 12) and direct access mode (bit 10) are 1. After reset the wake-up request is 0.
- R3: A pulse on evt_i[k] sets configuration bit k+1 from the next cycle on. The event bits map as follows: evt_i[0] is a read while buffers underrun, [1] is a read shorter than the output message, [2] is a read with no output queue entry, [3] is data sent while buffers overrun, [4] is data larger than the input buffer, and [5] is data sent with no input queue entry.
- R4: An error flag stays set until the configuration word is read. Writes do not clear it.
- R5: A configuration read returns the flags as they were before the access and then clears them. An event in the same cycle as the read stays set.
- R6: A configuration write updates bits 19:7 only. A word-mode value (bits 9:8) of 11 is stored as 00. The outputs cpu_rst_o, cpu_clk_dis_o, direct_mode_o and word_mode_o show bits 14, 12, 10 and 9:8.
- R7: irq_o is (bit 16 AND data_pend_i) OR (bit 17 AND wlan_rdy_i), with no cycle of delay.
- R8: The control word (address 1) reads frame_type_i in bits 15:14, wlan_rdy_i in bit 13, the wake-up request in bit 12 and next_len_i in bits 11:0. Bits 31:16 read 0. A write changes only bit 12, which drives wake_req_o.
- R9: reg_rdata_o is updated one cycle after a read request and holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 1 | 0 = configuration, 1 = control |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Registered read data |
| evt_i | input | 6 | Misuse event pulses |
| frame_type_i | input | 2 | Next frame type (11 data, 10 management, 01 indication, 00 confirmation) |
| wlan_rdy_i | input | 1 | Ready status |
| data_pend_i | input | 1 | Data interrupt pending |
| next_len_i | input | 12 | Length of next output item |
| irq_o | output | 1 | Interrupt request |
| cpu_rst_o | output | 1 | CPU reset control |
| cpu_clk_dis_o | output | 1 | CPU clock disable |
| direct_mode_o | output | 1 | 1 = direct access, 0 = queue mode |
| word_mode_o | output | 2 | Effective byte-ordering mode |
| wake_req_o | output | 1 | Wake-up request |

## Verification
Read data, the control outputs, the wake-up request and the error flags all change at the clock edge that samples the request or event. The bench drives its inputs on falling edges and samples at the next falling edge, which falls half a cycle after that active edge. irq_o is combinational, so it is sampled one nanosecond after its inputs change. Flag clearing is checked on a second read, because the first read must still return the flags as they were before the access.

// File: rtl/hif_reg_pkg.sv
package hif_reg_pkg;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned N_ERR  = 6;
  parameter int unsigned LEN_W  = 12;
  parameter logic [7:0]  DEV_ID = 8'h01;

  localparam logic [DATA_W-1:0] CFG_RW_MASK  = 32'h000F_FF80;
  localparam logic [DATA_W-1:0] CFG_RST_VAL  = 32'h0000_5400;
  localparam int unsigned       ERR_LSB      = 1;
  localparam int unsigned       WM_LSB       = 8;
  localparam int unsigned       IRQ_LSB      = 16;
  localparam int unsigned       WAKE_BIT     = 12;

  typedef enum logic {ADDR_CFG = 1'b0, ADDR_CTRL = 1'b1} reg_addr_e;
endpackage

// File: rtl/hif_err_flags.sv
module hif_err_flags #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flag_o[k] <= 1'b0;
      else if (evt_i[k])  flag_o[k] <= 1'b1;  // set wins over read-clear
      else if (clr_i)     flag_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/hif_cfg_store.sv
module hif_cfg_store
  import hif_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cfg_o,
  output logic              wake_o
);
  logic [DATA_W-1:0] wr_val;

  always_comb begin
    wr_val = wdata_i & CFG_RW_MASK;
    if (wr_val[WM_LSB+:2] == 2'b11) wr_val[WM_LSB+:2] = 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_o <= CFG_RST_VAL;
    else if (cfg_we_i) cfg_o <= wr_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        wake_o <= 1'b0;
    else if (ctrl_we_i) wake_o <= wdata_i[WAKE_BIT];
  end
endmodule

// File: rtl/hif_irq_gen.sv
module hif_irq_gen (
  input  logic [1:0] en_i,     // [1] ready enable, [0] data enable
  input  logic       data_pend_i,
  input  logic       wlan_rdy_i,
  output logic       irq_o
);
  assign irq_o = (en_i[0] & data_pend_i) | (en_i[1] & wlan_rdy_i);
endmodule

// File: rtl/hif_status_regs.sv
module hif_status_regs
  import hif_reg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic [N_ERR-1:0]  evt_i,
  input  logic [1:0]        frame_type_i,
  input  logic              wlan_rdy_i,
  input  logic              data_pend_i,
  input  logic [LEN_W-1:0]  next_len_i,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              cpu_clk_dis_o,
  output logic              direct_mode_o,
  output logic [1:0]        word_mode_o,
  output logic              wake_req_o
);
  localparam int unsigned CTRL_W = 16;

  logic              rd_cfg, wr_cfg, wr_ctrl, rd_any;
  logic [N_ERR-1:0]  err_q;
  logic [DATA_W-1:0] cfg_q, cfg_view, ctrl_view;

  assign rd_any  = reg_req_i & ~reg_we_i;
  assign rd_cfg  = rd_any & (reg_addr_i == ADDR_CFG);
  assign wr_cfg  = reg_req_i & reg_we_i & (reg_addr_i == ADDR_CFG);
  assign wr_ctrl = reg_req_i & reg_we_i & (reg_addr_i == ADDR_CTRL);

  hif_err_flags #(.N(N_ERR)) u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt_i),
    .clr_i  (rd_cfg),
    .flag_o (err_q)
  );

  hif_cfg_store u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_we_i  (wr_cfg),
    .ctrl_we_i (wr_ctrl),
    .wdata_i   (reg_wdata_i),
    .cfg_o     (cfg_q),
    .wake_o    (wake_req_o)
  );

  hif_irq_gen u_irq (
    .en_i        (cfg_q[IRQ_LSB+:2]),
    .data_pend_i (data_pend_i),
    .wlan_rdy_i  (wlan_rdy_i),
    .irq_o       (irq_o)
  );

  always_comb begin
    cfg_view = cfg_q;
    cfg_view[DATA_W-1 -: 8] = DEV_ID;
    cfg_view[ERR_LSB+:N_ERR] = err_q;
  end

  assign ctrl_view = {{(DATA_W-CTRL_W){1'b0}}, frame_type_i, wlan_rdy_i,
                      wake_req_o, next_len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     reg_rdata_o <= '0;
    else if (rd_any) reg_rdata_o <= (reg_addr_i == ADDR_CTRL) ? ctrl_view : cfg_view;
  end

  assign cpu_rst_o     = cfg_q[14];
  assign cpu_clk_dis_o = cfg_q[12];
  assign direct_mode_o = cfg_q[10];
  assign word_mode_o   = cfg_q[WM_LSB+:2];
endmodule

// File: rtl/hif_status_regs_chk.sv
module hif_status_regs_chk
  import hif_reg_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic              reg_addr_i,
  input logic [DATA_W-1:0] reg_wdata_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic [N_ERR-1:0]  evt_i,
  input logic              wlan_rdy_i,
  input logic              data_pend_i,
  input logic              irq_o,
  input logic [1:0]        word_mode_o,
  input logic              wake_req_o,
  input logic [N_ERR-1:0]  err_q
);
  logic rd_cfg, wr_cfg, wr_ctrl;
  assign rd_cfg  = reg_req_i & ~reg_we_i & ~reg_addr_i;
  assign wr_cfg  = reg_req_i & reg_we_i & ~reg_addr_i;
  assign wr_ctrl = reg_req_i & reg_we_i & reg_addr_i;

  AST_DEV_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cfg |=> (reg_rdata_o[31:24] == DEV_ID && reg_rdata_o[23:20] == 4'h0)); // R1
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((err_q & $past(evt_i)) == $past(evt_i))); // R3
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cfg |=> ((err_q & $past(err_q)) == $past(err_q))); // R4
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_cfg && evt_i == '0) |=> (err_q == '0)); // R5
  AST_WMODE_FOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cfg && reg_wdata_i[9:8] == 2'b11) |=> (word_mode_o == 2'b00)); // R6
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (data_pend_i || wlan_rdy_i)); // R7
  AST_WAKE_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ctrl |=> (wake_req_o == $past(reg_wdata_i[12]))); // R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_req_i && !reg_we_i) |=> $stable(reg_rdata_o)); // R9
endmodule

bind hif_status_regs hif_status_regs_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .evt_i       (evt_i),
  .wlan_rdy_i  (wlan_rdy_i),
  .data_pend_i (data_pend_i),
  .irq_o       (irq_o),
  .word_mode_o (word_mode_o),
  .wake_req_o  (wake_req_o),
  .err_q       (err_q)
);

// File: tb/hif_status_regs_tb.sv
module hif_status_regs_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_req_i = 1'b0, reg_we_i = 1'b0, reg_addr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [5:0]  evt_i = '0;
  logic [1:0]  frame_type_i = 2'b10;
  logic        wlan_rdy_i = 1'b0, data_pend_i = 1'b0;
  logic [11:0] next_len_i = 12'h123;
  logic        irq_o, cpu_rst_o, cpu_clk_dis_o, direct_mode_o, wake_req_o;
  logic [1:0]  word_mode_o;
  int          n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  hif_status_regs u_dut (.*);

  // {addr, wdata, expected read-back after write}
  localparam int NV = 6;
  localparam logic [64:0] VEC [NV] = '{
    {1'b0, 32'hFFFF_FFFF, 32'h010F_FC80},  // R6 fold 11 -> 00, R1 RO bits
    {1'b0, 32'h0000_0200, 32'h0100_0200},  // R6
    {1'b0, 32'h0000_0100, 32'h0100_0100},  // R6
    {1'b0, 32'hFFF0_007F, 32'h0100_0000},  // R1 RO bits ignored
    {1'b1, 32'h0000_FFFF, 32'h0000_9123},  // R8
    {1'b1, 32'h0000_0000, 32'h0000_8123}   // R8
  };

  task automatic check(input string req, input logic [31:0] act, exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic op(input logic we, addr, input logic [31:0] wd, input logic [5:0] ev);
    @(negedge clk_i);
    reg_req_i = 1'b1; reg_we_i = we; reg_addr_i = addr; reg_wdata_i = wd; evt_i = ev;
    @(negedge clk_i);
    reg_req_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse(input logic [5:0] ev);
    @(negedge clk_i); evt_i = ev;
    @(negedge clk_i); evt_i = '0;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 reset state
    check("R2 cpu_rst", {31'b0, cpu_rst_o}, 32'd1);
    check("R2 clk_dis", {31'b0, cpu_clk_dis_o}, 32'd1);
    check("R2 direct", {31'b0, direct_mode_o}, 32'd1);
    check("R2 wake", {31'b0, wake_req_o}, 32'd0);
    op(1'b0, 1'b0, '0, '0);
    check("R2 cfg reset", reg_rdata_o, 32'h0100_5400);

    for (int i = 0; i < NV; i++) begin
      op(1'b1, VEC[i][64], VEC[i][63:32], '0);
      op(1'b0, VEC[i][64], '0, '0);
      check("R6/R8 vector", reg_rdata_o, VEC[i][31:0]);
    end
    check("R6 word_mode", {30'b0, word_mode_o}, 32'd0);
    check("R8 wake off", {31'b0, wake_req_o}, 32'd0);

    // R9 read data holds through a write
    op(1'b1, 1'b0, 32'h0000_4000, '0);
    check("R9 hold", reg_rdata_o, 32'h0000_8123);
    check("R6 cpu_rst", {31'b0, cpu_rst_o}, 32'd1);

    // R7 irq enables
    op(1'b1, 1'b0, 32'h0001_0000, '0);  // data only
    wlan_rdy_i = 1'b1; #1;
    check("R7 rdy masked", {31'b0, irq_o}, 32'd0);
    data_pend_i = 1'b1; #1;
    check("R7 data irq", {31'b0, irq_o}, 32'd1);
    op(1'b1, 1'b0, 32'h0002_0000, '0);  // ready only
    wlan_rdy_i = 1'b0; #1;
    check("R7 data masked", {31'b0, irq_o}, 32'd0);
    wlan_rdy_i = 1'b1; #1;
    check("R7 rdy irq", {31'b0, irq_o}, 32'd1);
    wlan_rdy_i = 1'b0; data_pend_i = 1'b0;
    op(1'b1, 1'b0, 32'h0000_0000, '0);

    // R3 event mapping, R4 sticky
    pulse(6'b000001);
    pulse(6'b100000);
    repeat (4) @(negedge clk_i);
    op(1'b1, 1'b0, 32'h0000_007E, '0);  // write must not clear
    op(1'b0, 1'b0, '0, '0);
    check("R3/R4 flags", reg_rdata_o, 32'h0100_0042);
    op(1'b0, 1'b0, '0, '0);
    check("R5 cleared", reg_rdata_o, 32'h0100_0000);
    pulse(6'b011110);
    op(1'b0, 1'b0, '0, '0);
    check("R3 mid flags", reg_rdata_o, 32'h0100_003C);
    // R5 event coincident with read
    op(1'b0, 1'b0, '0, 6'b001000);
    check("R5 old value", reg_rdata_o, 32'h0100_0000);
    op(1'b0, 1'b0, '0, '0);
    check("R5 coincident kept", reg_rdata_o, 32'h0100_0010);
    // R8 live status
    frame_type_i = 2'b11; wlan_rdy_i = 1'b1; next_len_i = 12'hFFF;
    op(1'b0, 1'b1, '0, '0);
    check("R8 ctrl live", reg_rdata_o, 32'h0000_EFFF);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule